// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register side of a minimal serial port. A processor sees four 32-bit word registers through a plain memory-mapped read/write port: receive data, transmit data, status and control. Bytes that a receiver has already deserialised arrive on a valid/ready byte stream. They are held in an eight-entry circular buffer that is tracked by a write position and a fill count. Bytes written to the transmit register leave on a one-cycle output byte stream.

The block composes a status word from the buffer state and three error inputs from the serial engine. It also carries out the control actions and drives a level interrupt. The interrupt-pending flag is sticky. A transmit write sets it, and so does any cycle that ends with bytes in the buffer. Only reset clears it. The interrupt pin is this flag gated by an enable bit in the control register. Bit timing, baud generation and error detection belong to the serial engine outside this block.

Top module: `serial_reg_front`

## Requirements
- R1: The register is chosen by byte address bits [4:2]: 0 is RX data, 1 is TX data, 2 is status and 3 is control. Address bits [1:0] are ignored. Reads at word offsets 4 to 7 return zero.
- R2: After a synchronous active-high reset, the fill count is 0 and status reads 0x00000004. Control reads 0, `irq` and `txValid` are low, and `rxReady` is high.
- R3: Received bytes are read back from offset 0 oldest first. Order is kept across wraparound of the 8-entry circular buffer. Each such read removes one byte.
- R4: `rxReady` is low exactly when the buffer holds 8 bytes. A byte offered in that state is dropped, and the buffer contents are unchanged.
- R5: A read of offset 0 with an empty buffer leaves the count at zero.
- R6: The status layout is as follows. Bit 0 is set when the count is non-zero. Bit 1 is set when the count equals 8. Bit 2 always reads 1. Bit 3 always reads 0. Bit 4 is interrupt pending. Bits 5, 6 and 7 mirror `errIn[0]` (overrun), `errIn[1]` (framing) and `errIn[2]` (parity). Bits 31:8 read 0.
- R7: A write to offset 1 stores the full word, which reads back at offset 1. In the next cycle, the write raises `txValid` for exactly one cycle, with `txByte` equal to bits [7:0]. The write also sets interrupt pending.
- R8: Interrupt pending is set by a TX write or by a non-zero count after an update. Once set, it stays set until reset.
- R9: `irq` equals interrupt pending ANDed with control bit 4.
- R10: A write to offset 3 stores the full word, which reads back at offset 3. If bit 1 is set, the write empties the buffer (count and write position return to 0). This clear takes precedence over a byte arriving in the same cycle.
- R11: A write to offset 2 changes no state. In the next cycle, it raises `statusWrErr` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 5 | Byte address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (the read completes at the clock edge) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the current address, combinational |
| rxByte | input | 8 | Incoming byte |
| rxValid | input | 1 | Incoming byte valid |
| rxReady | output | 1 | Buffer can accept a byte |
| errIn | input | 3 | Overrun, framing and parity flags from the serial engine |
| txByte | output | 8 | Outgoing byte |
| txValid | output | 1 | One-cycle strobe for an outgoing byte |
| irq | output | 1 | Level interrupt |
| statusWrErr | output | 1 | One-cycle strobe after an illegal status write |

## Verification
The assertions assume that at most one of `busRdEn` and `busWrEn` is high in any cycle, and that `rxByte` is defined whenever `rxValid` is high. They also assume that the address is stable while a strobe is high. The stimulus drives every input on the falling edge and holds it until after the next rising edge. It issues at most one bus access per cycle. It sends a byte together with a bus write only in the deliberate test where a byte collides with a buffer clear.

// File: rtl/serial_reg_front_pkg.sv
package serial_reg_front_pkg;

  typedef enum logic [2:0] {
    SEL_RXDATA,
    SEL_TXDATA,
    SEL_STATUS,
    SEL_CONTROL,
    SEL_NONE
  } rdSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic popRx;
    logic wrTx;
    logic wrCtrl;
    logic rxClear;
    logic wrStatus;
  } strobes_t;

  localparam int OFF_RX     = 0;
  localparam int OFF_TX     = 1;
  localparam int OFF_STATUS = 2;
  localparam int OFF_CTRL   = 3;

  localparam int CTRL_RXCLR_BIT = 1;
  localparam int CTRL_IE_BIT    = 4;

endpackage

// File: rtl/serial_reg_front_ctrl.sv
module serial_reg_front_ctrl
  import serial_reg_front_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output strobes_t          stb,
  output rdSel_e            rdSel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              unusedByteLane;
  logic              unusedWrData;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedByteLane = ^busAddr[1:0];   // R1: byte lane ignored
  assign unusedWrData   = ^busWrData;

  always_comb begin
    rdSel = SEL_NONE;
    if (wordIdx == WORD_W'(OFF_RX))          rdSel = SEL_RXDATA;
    else if (wordIdx == WORD_W'(OFF_TX))     rdSel = SEL_TXDATA;
    else if (wordIdx == WORD_W'(OFF_STATUS)) rdSel = SEL_STATUS;
    else if (wordIdx == WORD_W'(OFF_CTRL))   rdSel = SEL_CONTROL;
  end

  always_comb begin
    stb          = '0;
    stb.popRx    = busRdEn && (rdSel == SEL_RXDATA);
    stb.wrTx     = busWrEn && (rdSel == SEL_TXDATA);
    stb.wrStatus = busWrEn && (rdSel == SEL_STATUS);
    stb.wrCtrl   = busWrEn && (rdSel == SEL_CONTROL);
    stb.rxClear  = stb.wrCtrl && busWrData[CTRL_RXCLR_BIT];
  end

endmodule

// File: rtl/serial_reg_front_dp.sv
module serial_reg_front_dp
  import serial_reg_front_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ERR_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          stb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [ERR_W-1:0]  errIn,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq,
  output logic              statusWrErr,
  output logic [CNT_W-1:0]  fillCount,
  output logic              intPending
);
  logic [BYTE_W-1:0] rxMem [DEPTH];
  logic [PTR_W-1:0]  wrPos;
  logic [PTR_W-1:0]  rdPos;
  logic [CNT_W-1:0]  countNext;
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] statusWord;
  logic              pushOk;
  logic              popOk;

  assign rxReady   = (fillCount != CNT_W'(DEPTH));               // R4
  assign pushOk    = rxValid && rxReady && !stb.rxClear;         // R10 clear wins
  assign popOk     = stb.popRx && (fillCount != '0);             // R5
  assign rdPos     = wrPos - fillCount[PTR_W-1:0];               // oldest entry
  assign countNext = stb.rxClear ? '0
                   : fillCount + CNT_W'(pushOk) - CNT_W'(popOk);

  // Buffer storage: one write-enabled slot per entry
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (pushOk && (wrPos == PTR_W'(g))) rxMem[g] <= rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPos       <= '0;
      fillCount   <= '0;
      intPending  <= 1'b0;
      txReg       <= '0;
      ctrlReg     <= '0;
      txValid     <= 1'b0;
      statusWrErr <= 1'b0;
    end else begin
      if (stb.rxClear)  wrPos <= '0;
      else if (pushOk)  wrPos <= wrPos + 1'b1;
      fillCount   <= countNext;
      intPending  <= intPending | stb.wrTx | (countNext != '0);  // R8
      if (stb.wrTx)   txReg   <= busWrData;
      if (stb.wrCtrl) ctrlReg <= busWrData;
      txValid     <= stb.wrTx;                                   // R7
      statusWrErr <= stb.wrStatus;                               // R11
    end
  end

  assign txByte = txReg[BYTE_W-1:0];
  assign irq    = intPending & ctrlReg[CTRL_IE_BIT];             // R9

  // R6 status layout
  always_comb begin
    statusWord    = '0;
    statusWord[0] = (fillCount != '0);
    statusWord[1] = (fillCount == CNT_W'(DEPTH));
    statusWord[2] = 1'b1;
    statusWord[3] = 1'b0;
    statusWord[4] = intPending;
    statusWord[5 +: ERR_W] = errIn;
  end

  always_comb begin
    unique case (rdSel)
      SEL_RXDATA:  busRdData = DATA_W'(rxMem[rdPos]);
      SEL_TXDATA:  busRdData = txReg;
      SEL_STATUS:  busRdData = statusWord;
      SEL_CONTROL: busRdData = ctrlReg;
      default:     busRdData = '0;
    endcase
  end

endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import serial_reg_front_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int ERR_W  = 3,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic [ERR_W-1:0]  errIn,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid,
  output logic              irq,
  output logic              statusWrErr
);
  strobes_t         stb;
  rdSel_e           rdSel;
  logic [CNT_W-1:0] fillCount;
  logic             intPending;

  serial_reg_front_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .stb(stb), .rdSel(rdSel)
  );

  serial_reg_front_dp #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .rdSel(rdSel),
    .busWrData(busWrData), .busRdData(busRdData),
    .rxByte(rxByte), .rxValid(rxValid), .rxReady(rxReady),
    .errIn(errIn), .txByte(txByte), .txValid(txValid),
    .irq(irq), .statusWrErr(statusWrErr),
    .fillCount(fillCount), .intPending(intPending)
  );

endmodule

// File: rtl/serial_reg_front_checker.sv
module serial_reg_front_checker #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic              rxValid,
  input logic              txValid,
  input logic              statusWrErr,
  input logic              irq,
  input logic [CNT_W-1:0]  fillCount,
  input logic              intPending
);
  logic [ADDR_W-3:0] word;
  assign word = busAddr[ADDR_W-1:2];

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fillCount <= CNT_W'(DEPTH));

  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    (rxValid && fillCount == CNT_W'(DEPTH) && !busRdEn && !busWrEn)
      |=> fillCount == CNT_W'(DEPTH));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (fillCount == '0 && busRdEn && word == '0 && !rxValid) |=> fillCount == '0);

  assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && word == 1) |=> txValid);

  assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !(busWrEn && word == 1) |=> !txValid);

  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    !$fell(intPending));

  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> intPending);

  assert_status_wr_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && word == 2) |=> statusWrErr);

  assert_status_wr_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !(busWrEn && word == 2) |=> !statusWrErr);

endmodule

bind serial_reg_front serial_reg_front_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .rxValid(rxValid), .txValid(txValid), .statusWrErr(statusWrErr), .irq(irq),
  .fillCount(fillCount), .intPending(intPending)
);

// File: tb/test_serial_reg_front.sv
`timescale 1ns/1ps
module test_serial_reg_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  rxByte = '0;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [2:0]  errIn = '0;
  logic [7:0]  txByte;
  logic        txValid;
  logic        irq;
  logic        statusWrErr;

  int checks = 0;
  int fails = 0;

  // reference model
  logic [7:0]  mdl [8];
  int          mWp = 0;
  int          mCnt = 0;
  logic        mPend = 1'b0;
  logic [31:0] mCtrl = '0;

  always #10 clk = ~clk;

  serial_reg_front i_serial_reg_front (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .rxByte(rxByte), .rxValid(rxValid),
    .rxReady(rxReady), .errIn(errIn), .txByte(txByte), .txValid(txValid),
    .irq(irq), .statusWrErr(statusWrErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus();
    return {24'h0, errIn, mPend, 1'b0, 1'b1, mCnt == 8, mCnt != 0};
  endfunction

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mWp = 0; mCnt = 0; mPend = 1'b0; mCtrl = '0;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1 busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(posedge clk); #1 busRdEn = 1'b0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); rxByte = b; rxValid = 1'b1;
    #1 chk("R4 ready", {31'h0, rxReady}, {31'h0, mCnt != 8});
    @(posedge clk); #1 rxValid = 1'b0;
    if (mCnt < 8) begin mdl[mWp] = b; mWp = (mWp + 1) % 8; mCnt++; end
    mPend = mPend | (mCnt != 0);
  endtask

  task automatic popByte();
    logic [31:0] d;
    busRead(5'd1 + 5'd0 - 5'd1 + 5'(mCnt % 4), d); // offset 0, varied byte lane (R1)
    if (mCnt > 0) begin
      chk("R3 order", d, {24'h0, mdl[(mWp - mCnt + 8) % 8]});
      mCnt--;
    end
    mPend = mPend | (mCnt != 0);
  endtask

  task automatic checkStatus(input string req);
    logic [31:0] d;
    busRead(5'd8, d);
    chk(req, d, expStatus());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    doReset();
    // R2 reset state
    checkStatus("R2 status");
    busRead(5'd12, d); chk("R2 ctrl", d, 32'h0);
    chk("R2 irq/txValid/ready", {29'h0, irq, txValid, rxReady}, 32'h1);

    // R1 decode with nonzero byte lane, R10 store
    busWrite(5'd15, 32'h0000_0010); mCtrl = 32'h10;
    busRead(5'd13, d); chk("R1 R10 ctrl readback", d, mCtrl);
    for (int a = 16; a < 32; a += 3) begin
      busRead(5'(a), d); chk("R1 unmapped zero", d, 32'h0);
    end
    chk("R9 no pending no irq", {31'h0, irq}, 32'h0);

    // R5 empty read
    popByte(); checkStatus("R5 empty read");

    // R3 R4 sweep with wraparound and overflow
    for (int round = 0; round < 8; round++) begin
      int nPush = (round * 5 + 3) % 11;
      int nPop  = (round * 3 + 2) % 10;
      for (int i = 0; i < nPush; i++) pushByte(8'(round * 37 + i * 11 + 1));
      checkStatus("R6 after push");
      for (int i = 0; i < nPop; i++) popByte();
      checkStatus("R6 after pop");
    end
    while (mCnt < 8) pushByte(8'(mCnt + 8'h40));
    pushByte(8'hEE);
    checkStatus("R4 full status");
    for (int i = 0; i < 8; i++) popByte();
    chk("R9 irq follows pending", {31'h0, irq}, {31'h0, mPend});

    // R6 error bits
    for (int e = 0; e < 8; e++) begin
      errIn = 3'(e);
      checkStatus("R6 err bits");
    end
    errIn = '0;

    // R9 gating
    busWrite(5'd12, 32'h0); mCtrl = '0;
    chk("R9 irq disabled", {31'h0, irq}, 32'h0);
    busWrite(5'd12, 32'h10); mCtrl = 32'h10;
    chk("R9 irq enabled", {31'h0, irq}, 32'h1);

    // R10 clear
    for (int i = 0; i < 4; i++) pushByte(8'(i + 8'h70));
    busWrite(5'd12, 32'h12); mCnt = 0; mWp = 0; mCtrl = 32'h12;
    checkStatus("R10 cleared");
    busRead(5'd12, d); chk("R10 ctrl stored", d, 32'h12);
    pushByte(8'h5A); popByte();
    // R10 clear beats same-cycle byte
    pushByte(8'h11);
    @(negedge clk); busAddr = 5'd12; busWrData = 32'h12; busWrEn = 1'b1;
    rxByte = 8'h99; rxValid = 1'b1;
    @(posedge clk); #1 busWrEn = 1'b0; rxValid = 1'b0;
    mCnt = 0; mWp = 0;
    checkStatus("R10 clear wins");

    // R11 status write ignored
    busWrite(5'd9, 32'hFFFF_FFFF);
    chk("R11 strobe", {31'h0, statusWrErr}, 32'h1);
    @(posedge clk); #1;
    chk("R11 strobe single", {31'h0, statusWrErr}, 32'h0);
    checkStatus("R11 status unchanged");

    // R7 R8 transmit after fresh reset
    doReset();
    checkStatus("R8 pending clear after reset");
    busWrite(5'd5, 32'h1234_56A5); mPend = 1'b1;
    chk("R7 txValid", {31'h0, txValid}, 32'h1);
    chk("R7 txByte", {24'h0, txByte}, 32'hA5);
    @(posedge clk); #1;
    chk("R7 txValid single", {31'h0, txValid}, 32'h0);
    busRead(5'd6, d); chk("R7 tx readback", d, 32'h1234_56A5);
    chk("R9 irq gated off", {31'h0, irq}, 32'h0);
    busWrite(5'd12, 32'h10); mCtrl = 32'h10;
    chk("R9 irq on", {31'h0, irq}, 32'h1);
    repeat (20) @(posedge clk);
    checkStatus("R8 pending sticky");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule